// File: doc/BRIEF.md
# Leaf Page Permission Checker

This block decides whether a memory access may proceed once a page-table walk has reached a leaf entry. It takes the 64-bit leaf entry and three attributes of the access: whether the requester is privileged, whether it is an instruction fetch, and whether it is a store. It then gives one of three verdicts. The access may go on to load the translation into the TLB, or it is refused for lack of permission, or it is refused because the entry's reference/change bits are not yet in the state the access needs.

The check is a single registered stage. A one-cycle strobe with the entry and attributes produces a one-cycle valid pulse one clock later, with exactly one verdict bit set. When both checks fail, the permission failure is reported. Bit positions below use big-endian numbering, where bit 0 is the most significant bit of the entry, so big-endian bit n is port bit `63-n`.

Top module: `leaf_perm_check`

## Requirements
- R1: A strobe on `req_valid` in cycle N gives `res_valid` high in cycle N+1 only. Without a strobe, `res_valid` stays low.
- R2: When `res_valid` is high, exactly one of `res_ok`, `res_perm_err` and `res_rc_err` is high. When `res_valid` is low, all three are low.
- R3: If authority bit 60 (privileged-only, port bit 3) is 1 and `req_priv` is 0, the result is a permission error whatever the other bits hold.
- R4: For a data access (`req_iside`=0) that passes R3, permission holds when read/write bit 62 (port bit 1) is 1, or when read bit 61 (port bit 2) is 1 and `req_store` is 0.
- R5: For an instruction fetch (`req_iside`=1) that passes R3, permission holds only when execute bit 63 (port bit 0) is 1 and attribute bit 58 (port bit 5, set for the non-idempotent and tolerant-I/O attribute codes 10 and 11) is 0.
- R6: The reference/change check passes when Reference bit 55 (port bit 8) is 1 and, for a store, Change bit 56 (port bit 7) is also 1.
- R7: A reference/change error is reported only when permission holds. A failed permission check gives a permission error even if the reference/change check also fails.
- R8: The result is ok exactly when both the permission check and the reference/change check pass.
- R9: Entry bits outside 55, 56, 58 and 60..63 have no effect on the result. This includes the real page number, the software bits and the low attribute bit 59.
- R10: During and directly after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe: check the entry and attributes now |
| req_pte | input | 64 | Leaf page-table entry |
| req_priv | input | 1 | Access is made in privileged state |
| req_iside | input | 1 | Access is an instruction fetch |
| req_store | input | 1 | Access is a store |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_ok | output | 1 | Access allowed, may proceed to the TLB load |
| res_perm_err | output | 1 | Access refused by permission |
| res_rc_err | output | 1 | Access refused by reference/change state |

## Verification
Every verdict is due exactly one clock after its strobe, because the block has a single register stage between the inputs and the outputs. The bench drives each request at a falling edge and samples the three verdict bits at the next falling edge, one rising edge later. At selected points it also samples one further falling edge later, to confirm the valid pulse has ended. The sweep covers all combinations of the nine low entry bits and the three attribute inputs, repeats each with opposite filler in the unused bits, and includes back-to-back strobes so that each cycle's verdict is tied to its own request.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    // Width of a leaf entry
    localparam int PTE_W = 64;

    // Field positions in big-endian numbering (bit 0 = MSB)
    localparam int BE_REF      = 55;
    localparam int BE_CHG      = 56;
    localparam int BE_ATT_HI   = 58;
    localparam int BE_AUTH_PRV = 60;
    localparam int BE_AUTH_RD  = 61;
    localparam int BE_AUTH_RW  = 62;
    localparam int BE_AUTH_EX  = 63;

    // Decoded fields of a leaf entry that the checks use
    typedef struct packed {
        logic priv_only;
        logic rd;
        logic rw;
        logic ex;
        logic inhibit;
        logic ref_bit;
        logic chg_bit;
    } leaf_fields_t;

    // One registered verdict
    typedef struct packed {
        logic valid;
        logic ok;
        logic perm_err;
        logic rc_err;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{valid: 1'b0, ok: 1'b0, perm_err: 1'b0, rc_err: 1'b0};

endpackage

// File: rtl/lpc_field_extract.sv
module lpc_field_extract
    import lpc_pkg::*;
#(
    parameter int W = PTE_W
) (
    input  logic [W-1:0]  pte,
    output leaf_fields_t  fields
);
    // Port index of a big-endian bit number
    localparam int IX_REF = W - 1 - BE_REF;
    localparam int IX_CHG = W - 1 - BE_CHG;
    localparam int IX_ATT = W - 1 - BE_ATT_HI;
    localparam int IX_PRV = W - 1 - BE_AUTH_PRV;
    localparam int IX_RD  = W - 1 - BE_AUTH_RD;
    localparam int IX_RW  = W - 1 - BE_AUTH_RW;
    localparam int IX_EX  = W - 1 - BE_AUTH_EX;

    always_comb begin
        fields.priv_only = pte[IX_PRV];
        fields.rd        = pte[IX_RD];
        fields.rw        = pte[IX_RW];
        fields.ex        = pte[IX_EX];
        fields.inhibit   = pte[IX_ATT];
        fields.ref_bit   = pte[IX_REF];
        fields.chg_bit   = pte[IX_CHG];
    end
endmodule

// File: rtl/lpc_auth_eval.sv
module lpc_auth_eval
    import lpc_pkg::*;
(
    input  leaf_fields_t fields,
    input  logic         priv,
    input  logic         iside,
    input  logic         store,
    output logic         perm_ok
);
    logic gate_open;
    logic data_ok;
    logic fetch_ok;

    always_comb begin
        gate_open = priv | ~fields.priv_only;
        data_ok   = fields.rw | (fields.rd & ~store);
        fetch_ok  = fields.ex & ~fields.inhibit;
        perm_ok   = gate_open & (iside ? fetch_ok : data_ok);
    end
endmodule

// File: rtl/lpc_rc_eval.sv
module lpc_rc_eval
    import lpc_pkg::*;
(
    input  leaf_fields_t fields,
    input  logic         store,
    output logic         rc_ok
);
    always_comb begin
        rc_ok = fields.ref_bit & (fields.chg_bit | ~store);
    end
endmodule

// File: rtl/leaf_perm_check.sv
module leaf_perm_check
    import lpc_pkg::*;
#(
    parameter int W = PTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] req_pte,
    input  logic         req_priv,
    input  logic         req_iside,
    input  logic         req_store,
    output logic         res_valid,
    output logic         res_ok,
    output logic         res_perm_err,
    output logic         res_rc_err
);
    localparam int IX_REF = W - 1 - BE_REF;
    localparam int IX_CHG = W - 1 - BE_CHG;
    localparam int IX_ATT = W - 1 - BE_ATT_HI;
    localparam int IX_PRV = W - 1 - BE_AUTH_PRV;
    localparam int IX_EX  = W - 1 - BE_AUTH_EX;

    leaf_fields_t fields;
    logic         perm_ok;
    logic         rc_ok;
    verdict_t     verdict_d;
    verdict_t     verdict_q;

    lpc_field_extract #(.W(W)) i_extract (
        .pte    (req_pte),
        .fields (fields)
    );

    lpc_auth_eval i_auth (
        .fields  (fields),
        .priv    (req_priv),
        .iside   (req_iside),
        .store   (req_store),
        .perm_ok (perm_ok)
    );

    lpc_rc_eval i_rc (
        .fields (fields),
        .store  (req_store),
        .rc_ok  (rc_ok)
    );

    // Next verdict: permission failure outranks reference/change failure
    always_comb begin
        verdict_d = VERDICT_IDLE;
        if (req_valid) begin
            verdict_d.valid    = 1'b1;
            verdict_d.ok       = perm_ok & rc_ok;
            verdict_d.perm_err = ~perm_ok;
            verdict_d.rc_err   = perm_ok & ~rc_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= VERDICT_IDLE;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign res_valid    = verdict_q.valid;
    assign res_ok       = verdict_q.ok;
    assign res_perm_err = verdict_q.perm_err;
    assign res_rc_err   = verdict_q.rc_err;

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid); // R1
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_ok, res_perm_err, res_rc_err}) == 1)); // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_ok | res_perm_err | res_rc_err)); // R2
    AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_pte[IX_PRV]) |=> res_perm_err); // R3
    AST_NO_EXEC_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_iside && (req_pte[IX_ATT] || !req_pte[IX_EX])) |=> res_perm_err); // R5
    AST_RC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!req_pte[IX_REF] || (req_store && !req_pte[IX_CHG]))) |=> !res_ok); // R6
endmodule

// File: tb/test_leaf_perm_check.sv
module test_leaf_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_pte = '0;
    logic        req_priv = 1'b0;
    logic        req_iside = 1'b0;
    logic        req_store = 1'b0;
    logic        res_valid, res_ok, res_perm_err, res_rc_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 1'b0;
    logic [63:0] noise = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    leaf_perm_check i_leaf_perm_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_pte      (req_pte),
        .req_priv     (req_priv),
        .req_iside    (req_iside),
        .req_store    (req_store),
        .res_valid    (res_valid),
        .res_ok       (res_ok),
        .res_perm_err (res_perm_err),
        .res_rc_err   (res_rc_err)
    );

    function automatic logic [3:0] model(input logic [63:0] p, input logic pr,
                                         input logic is, input logic st);
        logic gate, perm, rc;
        gate = pr | ~p[3];
        perm = gate & (is ? (p[0] & ~p[5]) : (p[1] | (p[2] & ~st)));
        rc   = p[8] & (p[7] | ~st);
        return {1'b1, perm & rc, ~perm, perm & ~rc};
    endfunction

    function automatic string tag_for(input logic [63:0] p, input logic pr,
                                      input logic is, input logic st);
        logic perm;
        if (!pr && p[3]) return "R3";
        perm = is ? (p[0] & ~p[5]) : (p[1] | (p[2] & ~st));
        if (!perm) return is ? "R5" : "R4";
        if (!(p[8] & (p[7] | ~st))) return "R7/R6";
        return "R8";
    endfunction

    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {res_valid, res_ok, res_perm_err, res_rc_err};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,ok,perm,rc} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step_noise();
        noise = noise ^ (noise << 13);
        noise = noise ^ (noise >> 7);
        noise = noise ^ (noise << 17);
    endtask

    // Drive one request and check its verdict one rising edge later
    task automatic run_one(input logic [63:0] p, input logic pr, input logic is,
                           input logic st, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_pte = p; req_priv = pr; req_iside = is; req_store = st;
        @(negedge clk);
        req_valid = 1'b0; req_pte = ~p;
        check4(tag, model(p, pr, is, st));
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10: outputs low during reset and right after it
        repeat (3) @(negedge clk);
        check4("R10 in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check4("R10 after reset", 4'b0000);

        // Exhaustive sweep over the nine low entry bits and the three attributes
        for (int a = 0; a < 8; a++) begin
            for (int lo = 0; lo < 512; lo++) begin
                logic [63:0] p;
                step_noise();
                p = (noise & ~64'h1FF) | 64'(lo);
                run_one(p, a[2], a[1], a[0], tag_for(p, a[2], a[1], a[0]));
                // R9: opposite filler in the unused bits gives the same verdict
                p = (~noise & ~64'h1FF) | 64'(lo);
                run_one(p, a[2], a[1], a[0], "R9");
                if (lo < 4) begin
                    @(negedge clk);
                    check4("R1 pulse ends", 4'b0000); // R1 and R2 when idle
                end
            end
        end

        // R1: back-to-back strobes, each verdict in its own cycle
        begin
            logic [63:0] pa, pb;
            pa = 64'h0000_0000_0000_0106; // ref set, rd+rw: data load ok
            pb = 64'h0000_0000_0000_0008; // priv-only, user: perm error
            @(negedge clk);
            req_valid = 1'b1; req_pte = pa; req_priv = 1'b0; req_iside = 1'b0; req_store = 1'b0;
            @(negedge clk);
            check4("R1 back-to-back first", model(pa, 1'b0, 1'b0, 1'b0));
            req_pte = pb;
            @(negedge clk);
            req_valid = 1'b0;
            check4("R1 back-to-back second", model(pb, 1'b0, 1'b0, 1'b0));
            @(negedge clk);
            check4("R1 idle after burst", 4'b0000);
        end

        // R5 directed: attribute codes 10 and 11 block fetch, 00 and 01 allow it
        for (int att = 0; att < 4; att++) begin
            logic [63:0] p;
            p = 64'h101 | (64'(att) << 4);
            run_one(p, 1'b1, 1'b1, 1'b0, "R5 attribute");
        end

        finish_run();
    end
endmodule